// File: doc/BRIEF.md
# Standby Burst-Mode Sequencer

This block decides when a current-mode converter should stop regulating continuously and drop into a low-power standby pattern. While in normal regulation it lets the PWM gate through and watches for a long stretch of timebase ticks with no gate request. Once that stretch is long enough, it parks the switch, raises a low-power bias flag so the controller draws less supply current, and waits for the feedback comparator to report that the output has sagged.

When feedback climbs back over the burst threshold, the block opens a switching window of fixed length with the reduced peak-current limit selected. At the end of the window it stops switching for one cycle and samples feedback. If feedback is still below threshold, it goes back to idle waiting. Otherwise it returns to normal regulation. All intervals are counted in ticks of an external timebase, with their lengths set by parameters.

Top module: `burst_sequencer`

## Requirements
- R1: While and after a synchronous reset, the block is in normal regulation: `gate_en`=1, `ipk_low`=0, `lp_bias`=0.
- R2: In normal regulation the outputs are `gate_en`=1, `ipk_low`=0, `lp_bias`=0, whatever the value of `fb_low`.
- R3: Normal regulation is left on the IDLE_TICKS-th `tick` seen without any `gate_req` since the last request (or since entry). A `gate_req` restarts that count, including when it falls in the same cycle as the final tick, and no switch is made in that cycle.
- R4: In idle wait the outputs are `gate_en`=0, `ipk_low`=0, `lp_bias`=1. The block stays there as long as `fb_low`=1.
- R5: In idle wait, a cycle with `fb_low`=0 starts a burst window in the next cycle, with outputs `gate_en`=1, `ipk_low`=1, `lp_bias`=0.
- R6: A burst window ends on its BURST_TICKS-th `tick`. It is followed by exactly one check cycle with `gate_en`=0, `ipk_low`=0, `lp_bias`=0.
- R7: In the check cycle, `fb_low`=1 leads to idle wait and `fb_low`=0 leads to normal regulation. A new inactivity count starts from zero on return.
- R8: `gate_req` has no effect outside normal regulation.
- R9: `fb_low` has no effect during normal regulation and during a burst window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe |
| gate_req | input | 1 | Normal-loop PWM gate request |
| fb_low | input | 1 | Feedback below burst threshold |
| gate_en | output | 1 | Permits the gate driver to switch |
| ipk_low | output | 1 | Selects the reduced peak-current limit |
| lp_bias | output | 1 | Low-power bias while switching is idle |

## Verification
Two events can fall in the same cycle: the tick that completes the inactivity count, and a gate request that should restart it. A directed sequence places the request exactly on the final tick. The judgement is that the outputs stay in normal regulation and that a full fresh count of ticks is then needed. A second collision is the last burst tick arriving while feedback changes. Random phases with heavy tick and feedback activity provoke it often, and every cycle is compared against a cycle-level model in the bench.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_BURST  = 2'd2,
        ST_CHECK  = 2'd3
    } burst_state_e;

    typedef struct packed {
        logic gate_en;
        logic ipk_low;
        logic lp_bias;
    } burst_out_t;

    function automatic burst_out_t decode_outs(burst_state_e st);
        burst_out_t o;
        o = '{gate_en: 1'b0, ipk_low: 1'b0, lp_bias: 1'b0};
        case (st)
            ST_NORMAL: o.gate_en = 1'b1;
            ST_IDLE:   o.lp_bias = 1'b1;
            ST_BURST:  begin
                o.gate_en = 1'b1;
                o.ipk_low = 1'b1;
            end
            default:   o = '{gate_en: 1'b0, ipk_low: 1'b0, lp_bias: 1'b0};
        endcase
        return o;
    endfunction

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/burst_tick_timer.sv
module burst_tick_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    assign done = tick && !clr && (cnt_q == CW'(limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (done) cnt_q <= '0;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end

    p_cnt_below_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(limit)) |-> (cnt_q < limit))
        else $error("timer count reached its limit");

    p_clr_zero_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0))
        else $error("timer not cleared");
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
#(
    parameter int unsigned IDLE_TICKS  = 14,
    parameter int unsigned BURST_TICKS = 14,
    parameter int unsigned CW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gate_req,
    input  logic          fb_low,
    input  logic          tmr_done,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_limit,
    output burst_state_e  state_q
);
    burst_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_NORMAL: if (tmr_done && !gate_req) state_d = ST_IDLE;
            ST_IDLE:   if (!fb_low)               state_d = ST_BURST;
            ST_BURST:  if (tmr_done)              state_d = ST_CHECK;
            ST_CHECK:  state_d = fb_low ? ST_IDLE : ST_NORMAL;
            default:   state_d = ST_NORMAL;
        endcase
    end

    always_comb begin
        tmr_clr = 1'b0;
        case (state_q)
            ST_NORMAL: tmr_clr = gate_req;
            ST_IDLE,
            ST_CHECK:  tmr_clr = 1'b1;
            default:   tmr_clr = 1'b0;
        endcase
    end

    assign tmr_limit = (state_q == ST_NORMAL) ? CW'(IDLE_TICKS) : CW'(BURST_TICKS);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_NORMAL;
        else     state_q <= state_d;
    end

    p_req_holds_normal_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && gate_req) |=> (state_q == ST_NORMAL))
        else $error("left normal despite gate request");

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && fb_low) |=> (state_q == ST_IDLE))
        else $error("left idle while feedback low");

    p_wake_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !fb_low) |=> (state_q == ST_BURST))
        else $error("no burst after feedback rose");

    p_check_single_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK) |=> (state_q != ST_CHECK))
        else $error("check lasted more than one cycle");

    p_check_decide_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK) |=> (state_q == ($past(fb_low) ? ST_IDLE : ST_NORMAL)))
        else $error("wrong decision after check");

    p_burst_from_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_BURST) |-> ($past(state_q) == ST_IDLE))
        else $error("burst entered from wrong state");
endmodule

// File: rtl/burst_out_map.sv
module burst_out_map
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  burst_state_e state_q,
    output logic         gate_en,
    output logic         ipk_low,
    output logic         lp_bias
);
    burst_out_t outs;

    always_comb outs = decode_outs(state_q);

    assign gate_en = outs.gate_en;
    assign ipk_low = outs.ipk_low;
    assign lp_bias = outs.lp_bias;

    p_lp_no_gate_r4: assert property (@(posedge clk) disable iff (rst)
        lp_bias |-> !gate_en)
        else $error("bias lowered while switching");

    p_ipk_only_switching_r5: assert property (@(posedge clk) disable iff (rst)
        ipk_low |-> (gate_en && !lp_bias))
        else $error("reduced limit outside burst window");

    p_onehot_mode_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lp_bias, ipk_low}))
        else $error("idle and burst flags together");
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import burst_pkg::*;
#(
    parameter int unsigned IDLE_TICKS  = 14,
    parameter int unsigned BURST_TICKS = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic gate_req,
    input  logic fb_low,
    output logic gate_en,
    output logic ipk_low,
    output logic lp_bias
);
    localparam int unsigned CW = cnt_width(IDLE_TICKS, BURST_TICKS);

    logic          tmr_clr;
    logic          tmr_done;
    logic [CW-1:0] tmr_limit;
    burst_state_e  state_q;

    burst_fsm #(
        .IDLE_TICKS (IDLE_TICKS),
        .BURST_TICKS(BURST_TICKS),
        .CW         (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .gate_req (gate_req),
        .fb_low   (fb_low),
        .tmr_done (tmr_done),
        .tmr_clr  (tmr_clr),
        .tmr_limit(tmr_limit),
        .state_q  (state_q)
    );

    burst_tick_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .tick (tick),
        .limit(tmr_limit),
        .done (tmr_done)
    );

    burst_out_map u_out (
        .clk    (clk),
        .rst    (rst),
        .state_q(state_q),
        .gate_en(gate_en),
        .ipk_low(ipk_low),
        .lp_bias(lp_bias)
    );
endmodule

// File: tb/tb_burst_sequencer.sv
module tb_burst_sequencer;
    localparam int unsigned IT = 5;
    localparam int unsigned BT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, gate_req = 1'b0, fb_low = 1'b0;
    logic gate_en, ipk_low, lp_bias;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    int m_st  = 0;   // 0 normal, 1 idle, 2 burst, 3 check
    int m_cnt = 0;

    burst_sequencer #(.IDLE_TICKS(IT), .BURST_TICKS(BT)) dut (
        .clk(clk), .rst(rst), .tick(tick), .gate_req(gate_req), .fb_low(fb_low),
        .gate_en(gate_en), .ipk_low(ipk_low), .lp_bias(lp_bias)
    );

    always #4 clk = ~clk;

    function automatic logic [2:0] exp_outs(int st);
        case (st)
            0:       return 3'b100;
            1:       return 3'b001;
            2:       return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    function automatic string st_req(int st);
        case (st)
            0:       return "R2";
            1:       return "R4";
            2:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_now(string req);
        logic [2:0] got, exp;
        got = {gate_en, ipk_low, lp_bias};
        exp = exp_outs(m_st);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: outputs got %b expected %b", req, cyc, got, exp);
        end
    endtask

    task automatic model_next(logic gr, logic tk, logic fl);
        case (m_st)
            0: if (gr) m_cnt = 0;
               else if (tk) begin
                   if (m_cnt == IT - 1) begin m_st = 1; m_cnt = 0; end
                   else m_cnt++;
               end
            1: begin m_cnt = 0; if (!fl) m_st = 2; end
            2: if (tk) begin
                   if (m_cnt == BT - 1) begin m_st = 3; m_cnt = 0; end
                   else m_cnt++;
               end
            default: begin m_cnt = 0; m_st = fl ? 1 : 0; end
        endcase
    endtask

    // at negedge: check current outputs, drive new inputs, advance model
    task automatic step(logic gr, logic tk, logic fl, string req);
        @(negedge clk);
        check_now((req == "") ? st_req(m_st) : req);
        gate_req = gr; tick = tk; fb_low = fl;
        model_next(gr, tk, fl);
        @(posedge clk);
        cyc++;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R1");
        rst = 1'b0;
        m_st = 0; m_cnt = 0;

        // R3: request on the final tick restarts the count
        for (int i = 0; i < IT - 1; i++) step(1'b0, 1'b1, 1'b1, "R3");
        step(1'b1, 1'b1, 1'b1, "R3");
        for (int i = 0; i < IT - 1; i++) step(1'b0, 1'b1, 1'b1, "R3");
        step(1'b0, 1'b0, 1'b1, "R3");   // still normal: one tick short
        step(1'b0, 1'b1, 1'b1, "R3");   // final tick
        step(1'b0, 1'b0, 1'b1, "R4");   // now idle
        // R8: gate request ignored while idle
        step(1'b1, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b0, "R8");   // feedback rises -> burst
        // R9: feedback ignored during burst; R6 window length
        for (int i = 0; i < BT; i++) step(1'b0, 1'b1, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b1, "R6");   // check cycle, fb low -> idle
        step(1'b0, 1'b0, 1'b0, "R7");   // idle, wake
        for (int i = 0; i < BT; i++) step(1'b1, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R6");   // check, fb high -> normal
        step(1'b0, 1'b0, 1'b1, "R7");   // normal, fb ignored
        step(1'b0, 1'b1, 1'b1, "R9");

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 1500; i++) begin
                logic gr, tk, fl;
                int gp, fp;
                gp = (ph == 0) ? 50 : (ph == 1) ? 5 : (ph == 2) ? 0 : 20;
                fp = (ph == 2) ? 80 : 50;
                tk = ($urandom % 3) == 0;
                gr = ($urandom % 100) < gp;
                fl = ($urandom % 100) < fp;
                step(gr, tk, fl, "");
            end
        end
        step(1'b0, 1'b0, 1'b0, "");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule